// File: doc/BRIEF.md
# Dual-Mode Processor Counter Timer

This block is one processor's timer slice. A mode input, driven from a system-level configuration bit, selects between two personalities. In counter mode the block is a 22-bit limit-compare counter that sits at bit 9 of a 31-bit value. Each tick advances it by one. When it reaches the programmed limit it returns to zero, sets a reached flag and raises an interrupt. A limit of zero makes it run freely with no interrupt. In user mode the same four word offsets become the two halves of a 63-bit up-counter. Software loads the halves and starts or stops the counter through a status word. Reaching the top of the count sets the reached flag but never raises the interrupt.

The block watches the mode input for edges. It applies the actions of each transition in the clock cycle after the edge, and those actions take priority over any access in that cycle. Reads return data combinationally from `addr`. A read strobe is needed only where a read has a side effect.

Top module: `dm_cpu_timer`

## Requirements
- R1: After reset the block is in counter mode with count 0, limit 0, reached flag 0, interrupt low and running state 1. Offset 3 reads 0x00000001 and offset 1 reads 0x00000000.
- R2: In counter mode, a write to offset 0 keeps bits 30..9 of the data as the limit (mask 0x7FFFFE00), clears the count and lowers the interrupt. Each cycle with `tick` high adds 0x200 to the value read at offset 1, which is {reached in bit 31, count in bits 30..9, zeros in bits 8..0}.
- R3: In counter mode, the tick that brings the count to a nonzero limit instead returns the count to 0, sets the reached flag and raises `irq` one clock later.
- R4: In counter mode, a strobed read of offset 0 returns the limit in bits 30..9 and clears both the reached flag and `irq`.
- R5: In counter mode, a write to offset 2 sets the limit with the same mask and leaves the count unchanged.
- R6: In counter mode with a limit of 0, the counter runs freely. It wraps only after 0x3FFFFF periods and raises no interrupt before that.
- R7: In counter mode, writes to offsets 1 and 3 have no effect. The counter keeps running and offset 3 reads 1.
- R8: On a rising edge of `user_mode`, the block lowers `irq`, clears the reached flag and the running state, and keeps the count frozen until it is started.
- R9: In user mode, a write to offset 0 loads count bits 62..32 from data bits 30..0. A write to offset 1 loads count bits 31..9 from data bits 31..9. Offset 0 reads {reached, count[62:32]} and offset 1 reads {count[31:9], 9'b0}.
- R10: In user mode, writing offset 3 with bit 0 set starts the counter and writing it with bit 0 clear stops it. Offset 3 reads the running state in bit 0. A stopped counter ignores ticks.
- R11: In user mode, a carry from bit 31 into bit 32 of the count happens on the same tick.
- R12: In user mode, the tick that brings the count to 0x7FFFFFFFFFFFFE00 instead returns it to 0 and sets the reached flag, and `irq` stays low.
- R13: On a falling edge of `user_mode`, the block clears the count and the limit (free-run) and sets the running state to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one period per high cycle |
| user_mode | input | 1 | 1 selects user mode, 0 selects counter mode |
| addr | input | 2 | Word offset of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (used for read side effects) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt, counter mode only |

## Verification
The bench parks an interrupt and then enters user mode, so a design that skipped the clear on that edge would hold `irq` high while in user mode. It loads a low half one period below the top and ticks once. A design that split the carry would show a stale upper half. It also loads the last period before the 63-bit top, where a design that raised the interrupt or failed to wrap would be caught. It moves the limit below the count with offset 2 and checks that the count survives. A design that cleared it, or that ignored the offset 1 and offset 3 writes in the wrong mode, would show a count that differs from the expected value.

// File: rtl/dm_timer_pkg.sv
// Package: shared widths and register offsets of the dual-mode timer.
// Assumes a 32-bit word and a count that advances at bit FRAC_W.
package dm_timer_pkg;
    localparam int WORD_W = 32;
    localparam int FRAC_W = 9;
    localparam int SYS_W  = WORD_W - 1 - FRAC_W;   // counter-mode period bits
    localparam int HI_W   = WORD_W - 1;            // user upper half bits
    localparam int LO_W   = WORD_W - FRAC_W;       // user lower half bits
    localparam int CNT_W  = HI_W + LO_W;           // user period bits

    typedef enum logic [1:0] {
        OFS_LIM_HI  = 2'd0,
        OFS_CNT_LO  = 2'd1,
        OFS_LIM_NR  = 2'd2,
        OFS_STATUS  = 2'd3
    } ofs_e;
endpackage

// File: rtl/tmr_mode_edge.sv
// Module: registers the mode input and flags its rising and falling edges.
// Assumes mode is synchronous to clk; reset value is counter mode.
module tmr_mode_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_in,
    output logic mode_q,
    output logic rise,
    output logic fall
);
    // Hold last cycle's mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_in;
    end

    assign rise = mode_in & ~mode_q;
    assign fall = ~mode_in & mode_q;
endmodule

// File: rtl/tmr_count_core.sv
// Module: period counter with clear, load and compare-to-terminal.
// Assumes clear beats load, and load beats advance, in one cycle. In the
// narrow mode only the low SW bits count and the upper bits are held at zero.
module tmr_count_core #(
    parameter int CW = 54,
    parameter int SW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          adv,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] term,
    output logic [CW-1:0] cnt,
    output logic          hit
);
    logic [CW-1:0] nxt;
    logic [SW-1:0] nxt_narrow;

    // Next value in the active width.
    always_comb begin
        nxt_narrow = cnt[SW-1:0] + 1'b1;
        if (wide) nxt = cnt + 1'b1;
        else      nxt = {{(CW-SW){1'b0}}, nxt_narrow};
    end

    assign hit = adv && !clr && !load && (nxt == term);

    // Count register update by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (load) cnt <= load_val;
        else if (hit)  cnt <= '0;
        else if (adv)  cnt <= nxt;
    end

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt == '0));
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr && !load) |=> $stable(cnt));
endmodule

// File: rtl/tmr_read_mux.sv
// Module: selects read data by offset and mode.
// Assumes inputs are the live register state; purely combinational.
module tmr_read_mux
    import dm_timer_pkg::*;
(
    input  logic [1:0]       addr,
    input  logic             user,
    input  logic             reached,
    input  logic             running,
    input  logic [SYS_W-1:0] limit,
    input  logic [CNT_W-1:0] cnt,
    output logic [WORD_W-1:0] rdata
);
    // Pick the word for this offset.
    always_comb begin
        rdata = '0;
        case (ofs_e'(addr))
            OFS_LIM_HI: rdata = user ? {reached, cnt[CNT_W-1:LO_W]}
                                     : {1'b0, limit, {FRAC_W{1'b0}}};
            OFS_CNT_LO: rdata = user ? {cnt[LO_W-1:0], {FRAC_W{1'b0}}}
                                     : {reached, cnt[SYS_W-1:0], {FRAC_W{1'b0}}};
            OFS_STATUS: rdata = {{(WORD_W-1){1'b0}}, running};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/dm_cpu_timer.sv
// Module: per-processor timer with counter mode and user mode.
// Assumes a single access per cycle; mode transitions override accesses.
module dm_cpu_timer
    import dm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              user_mode,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);
    logic             mode_q, m_rise, m_fall, trans;
    logic             reached, running;
    logic [SYS_W-1:0] limit;
    logic [CNT_W-1:0] cnt, load_val, term;
    logic             hit, adv, clr, load;
    logic             wr_lim, wr_nr, wr_hi_u, wr_lo_u, wr_st_u, rd_lim;

    tmr_mode_edge u_edge (
        .clk(clk), .rst_n(rst_n), .mode_in(user_mode),
        .mode_q(mode_q), .rise(m_rise), .fall(m_fall)
    );

    assign trans   = m_rise | m_fall;
    assign wr_lim  = wr_en && !trans && !user_mode && addr == OFS_LIM_HI;
    assign wr_nr   = wr_en && !trans && !user_mode && addr == OFS_LIM_NR;
    assign wr_hi_u = wr_en && !trans &&  user_mode && addr == OFS_LIM_HI;
    assign wr_lo_u = wr_en && !trans &&  user_mode && addr == OFS_CNT_LO;
    assign wr_st_u = wr_en && !trans &&  user_mode && addr == OFS_STATUS;
    assign rd_lim  = rd_en && !trans && !user_mode && addr == OFS_LIM_HI;

    // Core controls and terminal period.
    always_comb begin
        clr  = m_fall | wr_lim;
        load = wr_hi_u | wr_lo_u;
        adv  = tick && !trans && (user_mode ? running : 1'b1);
        if (wr_hi_u) load_val = {wdata[HI_W-1:0], cnt[LO_W-1:0]};
        else         load_val = {cnt[CNT_W-1:LO_W], wdata[WORD_W-1:FRAC_W]};
        if (user_mode)        term = '1;
        else if (limit == '0) term = {{(CNT_W-SYS_W){1'b0}}, {SYS_W{1'b1}}};
        else                  term = {{(CNT_W-SYS_W){1'b0}}, limit};
    end

    tmr_count_core #(.CW(CNT_W), .SW(SYS_W)) u_core (
        .clk(clk), .rst_n(rst_n), .wide(user_mode), .adv(adv), .clr(clr),
        .load(load), .load_val(load_val), .term(term), .cnt(cnt), .hit(hit)
    );

    // Limit register.
    always_ff @(posedge clk) begin
        if (!rst_n)               limit <= '0;
        else if (m_fall)          limit <= '0;
        else if (wr_lim || wr_nr) limit <= wdata[WORD_W-2:FRAC_W];
    end

    // Running state.
    always_ff @(posedge clk) begin
        if (!rst_n)       running <= 1'b1;
        else if (m_rise)  running <= 1'b0;
        else if (m_fall)  running <= 1'b1;
        else if (wr_st_u) running <= wdata[0];
    end

    // Reached flag and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reached <= 1'b0;
            irq     <= 1'b0;
        end else if (m_rise) begin
            reached <= 1'b0;
            irq     <= 1'b0;
        end else if (hit) begin
            reached <= 1'b1;
            irq     <= !user_mode;
        end else begin
            if (rd_lim)          reached <= 1'b0;
            if (rd_lim || wr_lim) irq    <= 1'b0;
        end
    end

    tmr_read_mux u_rmux (
        .addr(addr), .user(user_mode), .reached(reached), .running(running),
        .limit(limit), .cnt(cnt), .rdata(rdata)
    );

    // R8
    enter_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q) |-> (!running && !irq && !reached));
    // R13
    leave_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_q) |-> (running && limit == '0));
    // R12
    user_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> !irq);
    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lim && !hit) |=> (!irq && !reached));
    // R3
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> reached);
endmodule

// File: tb/dm_cpu_timer_tb.sv
module dm_cpu_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        user_mode = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int total = 0;
    int bad = 0;
    logic [31:0] got;

    always #5 clk = ~clk;

    dm_cpu_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        addr = a; #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk); user_mode = m;
        @(negedge clk);
    endtask

    task automatic t_reset;
        peek(2'd1, got); chk("R1 count", got, 32'h0);
        peek(2'd3, got); chk("R1 status", got, 32'h1);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        peek(2'd0, got); chk("R1 limit", got, 32'h0);
    endtask

    task automatic t_limit;
        wr(2'd0, 32'hFFFF_FBFF);
        rd(2'd0, got); chk("R2 mask", got, 32'h7FFF_FA00);
        wr(2'd0, 32'h0000_0A00);
        ticks(4);
        peek(2'd1, got); chk("R2 count", got, 32'h0000_0800);
        chk("R3 no irq early", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R3 irq", {31'b0, irq}, 32'h1);
        peek(2'd1, got); chk("R3 wrap reached", got, 32'h8000_0000);
        rd(2'd0, got); chk("R4 read limit", got, 32'h0000_0A00);
        chk("R4 irq clear", {31'b0, irq}, 32'h0);
        peek(2'd1, got); chk("R4 reached clear", got, 32'h0);
    endtask

    task automatic t_noreset;
        ticks(3);
        wr(2'd2, 32'h0000_1000);
        peek(2'd1, got); chk("R5 count kept", got, 32'h0000_0600);
        ticks(4);
        chk("R5 no irq", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R5 irq at new limit", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0);
        chk("R2 write lowers irq", {31'b0, irq}, 32'h0);
        ticks(10);
        peek(2'd1, got); chk("R6 free run", got, 32'h8000_1400);
        chk("R6 no irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ignored;
        rd(2'd0, got);
        wr(2'd1, 32'h1234_5600);
        peek(2'd1, got); chk("R7 lo write ignored", got, 32'h0000_1400);
        wr(2'd3, 32'h0);
        peek(2'd3, got); chk("R7 status", got, 32'h1);
        ticks(2);
        peek(2'd1, got); chk("R7 still runs", got, 32'h0000_1800);
    endtask

    task automatic t_enter_user;
        wr(2'd0, 32'h0000_0400);
        ticks(2);
        chk("R8 pre irq", {31'b0, irq}, 32'h1);
        set_mode(1'b1);
        chk("R8 irq low", {31'b0, irq}, 32'h0);
        peek(2'd3, got); chk("R8 stopped", got, 32'h0);
        peek(2'd0, got); chk("R8 reached clear", got, 32'h0);
        ticks(3);
        peek(2'd1, got); chk("R8 frozen", got, 32'h0);
    endtask

    task automatic t_user;
        wr(2'd0, 32'hFFFF_FF12);
        wr(2'd1, 32'hABCD_E1FF);
        peek(2'd0, got); chk("R9 hi", got, 32'h7FFF_FF12);
        peek(2'd1, got); chk("R9 lo", got, 32'hABCD_E000);
        wr(2'd0, 32'h0000_0012);
        wr(2'd3, 32'h1);
        peek(2'd3, got); chk("R10 started", got, 32'h1);
        ticks(4);
        peek(2'd1, got); chk("R10 counts", got, 32'hABCD_E800);
        wr(2'd0, 32'h5); wr(2'd1, 32'hFFFF_FE00);
        ticks(1);
        peek(2'd0, got); chk("R11 hi carry", got, 32'h6);
        peek(2'd1, got); chk("R11 lo wrap", got, 32'h0);
        wr(2'd0, 32'h7FFF_FFFF); wr(2'd1, 32'hFFFF_FC00);
        ticks(1);
        peek(2'd0, got); chk("R12 reached", got, 32'h8000_0000);
        peek(2'd1, got); chk("R12 lo zero", got, 32'h0);
        chk("R12 no irq", {31'b0, irq}, 32'h0);
        wr(2'd3, 32'h0);
        peek(2'd3, got); chk("R10 stopped", got, 32'h0);
        ticks(3);
        peek(2'd1, got); chk("R10 frozen", got, 32'h0);
    endtask

    task automatic t_leave_user;
        wr(2'd1, 32'h0000_4000);
        set_mode(1'b0);
        peek(2'd3, got); chk("R13 running", got, 32'h1);
        peek(2'd1, got); chk("R13 count clear", got, 32'h8000_0000);
        peek(2'd0, got); chk("R13 limit clear", got, 32'h0);
        ticks(2);
        peek(2'd1, got); chk("R13 counts", got, 32'h8000_0400);
        chk("R13 no irq", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_limit();
        t_noreset();
        t_ignored();
        t_enter_user();
        t_user();
        t_leave_user();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule